// File: doc/BRIEF.md
# DMA Request Qualifier with Edge Sequencer

This block takes the active-low external request pin of one DMA channel and turns it into a one-cycle transfer request pulse for the channel engine. The pin runs through a multi-flop synchronizer into the controller clock domain. A small sequencer then decides when a request may be issued. The sequencer is driven by the channel enable, a sensing mode select and a done pulse that the engine returns when the transfer has completed.

In level sensing, a low pin is accepted whenever the channel is ready for it. A fresh request therefore follows each completed transfer for as long as the pin stays low.

In edge sensing, the sequencer steps through a fixed ring of three states: armed (waiting to see the pin low), pending (waiting for the engine to finish) and blocked (waiting to see the pin high). Enabling the channel always starts the sequencer in the armed state. The first request after enabling is therefore taken on the level alone, and a pin that was already low before enabling counts as a request. Clearing the enable returns the sequencer to idle at once, and any transfer it was waiting on is forgotten.

Top module: `dma_req_qual`

## Requirements
- R1: After reset, `xfer_req` is 0.
- R2: While the channel is enabled and armed, a pin that falls to 0 and stays there raises `xfer_req` exactly SYNC_STAGES+1 rising clock edges after the change. The first sampling edge counts as edge 1.
- R3: While `chan_en` is 0, `xfer_req` stays 0 whatever the pin does. Dropping `chan_en` while a transfer is pending discards it. After `chan_en` returns to 1 with the pin held at 0, `xfer_req` rises on the second edge.
- R4: `xfer_req` lasts exactly one cycle. No further pulse is issued until `xfer_done` has been seen, or until the channel has been disabled and enabled again.
- R5: With `edge_mode` = 0 (level sensing), a `xfer_done` pulse while a transfer is pending leads to a new `xfer_req` on the second edge if the synchronized pin is still 0. If the pin is 1, no pulse follows.
- R6: With `edge_mode` = 1 (edge sensing), after `xfer_done` no new pulse is issued while the pin stays 0.
- R7: With `edge_mode` = 1, enabling the channel while the pin is already 0 raises `xfer_req` on the second edge after `chan_en` goes to 1.
- R8: `xfer_done` has no effect unless a transfer is pending. It neither releases the blocked state nor disturbs the armed state.
- R9: In edge sensing, the pin must be seen at 1 before the sequencer re-arms. A later fall to 0 then gives one pulse SYNC_STAGES+1 edges after the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable |
| edge_mode | input | 1 | 1 = edge sensing, 0 = level sensing |
| xfer_done | input | 1 | One-cycle pulse from the engine when a transfer completes |
| dreq_n | input | 1 | Raw asynchronous request pin, active low |
| xfer_req | output | 1 | One-cycle transfer request pulse to the engine |

## Verification
The bench builds the block with SYNC_STAGES = 3 instead of the default 2. This checks that every latency tracks the parameter: the measured delay from pin fall to pulse is four edges, not a fixed three. With the deeper chain, the blocked-to-armed release in edge sensing and the two-edge restart after enable can be told apart by cycle count. The done pulse is placed in each of the pending, blocked and armed states, so that it is shown to act only where a transfer is outstanding.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ARM   = 2'd1,
      SQ_PEND  = 2'd2,
      SQ_BLOCK = 2'd3
   } seq_state_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/dmarq_sync.sv
module dmarq_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   import dmarq_pkg::*;

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
      $error("dmarq_sync: STAGES below minimum");
   end

   logic [LAST:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RESET_VAL;
      else        chain[0] <= din;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= RESET_VAL;
         else        chain[i] <= chain[i-1];
      end
   end

   assign dout = chain[LAST];

endmodule

// File: rtl/dmarq_seq.sv
module dmarq_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic edge_sel,
   input  logic done,
   input  logic req_low,
   output logic pulse
);
   import dmarq_pkg::*;

   seq_state_e state_q, state_d;
   logic       accept;

   // A request is taken only from the armed state.
   assign accept = en && (state_q == SQ_ARM) && req_low;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE:  if (en)       state_d = SQ_ARM;
         SQ_ARM:   if (req_low)  state_d = SQ_PEND;
         SQ_PEND:  if (done)     state_d = edge_sel ? SQ_BLOCK : SQ_ARM;
         SQ_BLOCK: if (!req_low) state_d = SQ_ARM;
         default:                state_d = SQ_IDLE;
      endcase
      if (!en) state_d = SQ_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         pulse   <= 1'b0;
      end else begin
         state_q <= state_d;
         pulse   <= accept;
      end
   end

endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chan_en,
   input  logic edge_mode,
   input  logic xfer_done,
   input  logic dreq_n,
   output logic xfer_req
);
   import dmarq_pkg::*;

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("dma_req_qual: SYNC_STAGES below minimum");
   end

   logic dreq_n_s;
   logic req_low_s;

   dmarq_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (dreq_n),
      .dout  (dreq_n_s)
   );

   assign req_low_s = ~dreq_n_s;

   dmarq_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (chan_en),
      .edge_sel (edge_mode),
      .done     (xfer_done),
      .req_low  (req_low_s),
      .pulse    (xfer_req)
   );

endmodule

// File: rtl/dma_req_qual_chk.sv
module dma_req_qual_chk (
   input logic clk,
   input logic rst_n,
   input logic chan_en,
   input logic edge_mode,
   input logic xfer_done,
   input logic req_low_s,
   input logic xfer_req
);
   // Independent model: a transfer is outstanding from its pulse until done or disable.
   logic outstanding;
   logic need_high;
   logic pending;

   assign pending = outstanding || xfer_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outstanding <= 1'b0;
         need_high   <= 1'b0;
      end else begin
         outstanding <= chan_en && pending && !xfer_done;
         if (!chan_en)                            need_high <= 1'b0;
         else if (pending && xfer_done && edge_mode) need_high <= 1'b1;
         else if (!req_low_s)                     need_high <= 1'b0;
      end
   end

   p_req_from_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> $past(req_low_s));

   p_quiet_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !xfer_req);

   p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> !outstanding);

   p_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |=> !xfer_req);

   p_high_before_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> !need_high);

endmodule

bind dma_req_qual dma_req_qual_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chan_en   (chan_en),
   .edge_mode (edge_mode),
   .xfer_done (xfer_done),
   .req_low_s (req_low_s),
   .xfer_req  (xfer_req)
);

// File: tb/dma_req_qual_tb.sv
module dma_req_qual_tb;

   localparam int SYNC = 3;
   localparam int LAT  = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_en = 1'b0;
   logic edge_mode = 1'b0;
   logic xfer_done = 1'b0;
   logic dreq_n = 1'b1;
   logic xfer_req;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_req_qual #(.SYNC_STAGES(SYNC)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_en   (chan_en),
      .edge_mode (edge_mode),
      .xfer_done (xfer_done),
      .dreq_n    (dreq_n),
      .xfer_req  (xfer_req)
   );

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Steps n cycles; returns index of first pulse (0 if none) and pulse count.
   task automatic watch(input int n, output int first, output int cnt);
      first = 0;
      cnt   = 0;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         if (xfer_req) begin
            cnt++;
            if (first == 0) first = k;
         end
      end
   endtask

   task automatic done_pulse();
      xfer_done = 1'b1;
      step(1);
      xfer_done = 1'b0;
   endtask

   task automatic t_reset();
      step(2);
      check(xfer_req == 1'b0, "R1 reset", int'(xfer_req), 0);
      rst_n = 1'b1;
      step(1);
      check(xfer_req == 1'b0, "R1 after release", int'(xfer_req), 0);
   endtask

   task automatic t_disabled();
      int f, c;
      chan_en = 1'b0;
      dreq_n  = 1'b0;
      watch(12, f, c);
      check(c == 0, "R3 disabled pin low", c, 0);
      dreq_n = 1'b1;
      step(LAT + 1);
   endtask

   task automatic t_level_latency();
      int f, c;
      edge_mode = 1'b0;
      chan_en   = 1'b1;
      step(3);
      dreq_n = 1'b0;
      watch(12, f, c);
      check(f == LAT, "R2 fall-to-pulse latency", f, LAT);
      check(c == 1, "R4 single pulse without done", c, 1);
   endtask

   task automatic t_level_rerequest();
      int f, c;
      done_pulse();
      watch(6, f, c);
      check(f == 1, "R5 rerequest second edge after done", f, 1);
      check(c == 1, "R5 rerequest count", c, 1);
      dreq_n = 1'b1;
      step(LAT + 1);
      done_pulse();
      watch(8, f, c);
      check(c == 0, "R5 no rerequest pin high", c, 0);
   endtask

   task automatic t_edge_mode();
      int f, c;
      chan_en   = 1'b0;
      step(2);
      edge_mode = 1'b1;
      dreq_n    = 1'b0;
      step(SYNC + 2);
      chan_en = 1'b1;
      watch(6, f, c);
      check(f == 2, "R7 first pulse on level after enable", f, 2);
      check(c == 1, "R7 pulse count", c, 1);
      done_pulse();
      watch(10, f, c);
      check(c == 0, "R6 no pulse while pin stays low", c, 0);
      done_pulse();
      watch(6, f, c);
      check(c == 0, "R8 done in blocked state ignored", c, 0);
      dreq_n = 1'b1;
      step(SYNC + 2);
      dreq_n = 1'b0;
      watch(10, f, c);
      check(f == LAT, "R9 rearm then fall latency", f, LAT);
      check(c == 1, "R9 pulse count", c, 1);
   endtask

   task automatic t_disable_pending();
      int f, c;
      chan_en = 1'b0;
      watch(4, f, c);
      check(c == 0, "R3 no pulse after disable in pending", c, 0);
      chan_en = 1'b1;
      watch(6, f, c);
      check(f == 2, "R3 restart after discarded transfer", f, 2);
      check(c == 1, "R3 restart count", c, 1);
   endtask

   task automatic t_done_in_arm();
      int f, c;
      done_pulse();
      dreq_n = 1'b1;
      step(SYNC + 2);
      done_pulse();
      step(2);
      dreq_n = 1'b0;
      watch(10, f, c);
      check(f == LAT, "R8 done in armed state ignored", f, LAT);
      check(c == 1, "R8 armed pulse count", c, 1);
   endtask

   initial begin
      t_reset();
      t_disabled();
      t_level_latency();
      t_level_rerequest();
      t_edge_mode();
      t_disable_pending();
      t_done_in_arm();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule